// File: doc/BRIEF.md
# Register Read History Buffer

This block keeps a short record of recent register-file operand reads, so that a processor can back up by a few instructions after a transient fault and still find each source register holding the value it had when those instructions first read it. Each issued instruction supplies the register index and value on its first source bus and on its second source bus. Both pairs are recorded in one lane per bus. Each lane keeps the most recent `DEPTH` instructions, so with both lanes full the block holds 2·`DEPTH` entries and capture never has to stall.

When a rollback of k instructions is requested, the block drives the saved pairs back into the register file through a single write port, one per cycle. It starts at the newest instruction and works towards the oldest. For each instruction it writes the second-source entry first and the first-source entry second. A register that was read more than once inside the rolled-back span therefore ends up holding its oldest value. While this runs, `busy` is high and new captures and new rollback requests are ignored. The restored instructions are dropped from the history. Older ones stay and can be restored by a later request.

A request for more instructions than are held is cut down to the number held, and `clamp_err` is raised for one cycle. A request for zero instructions holds `busy` high for one cycle and writes nothing.

Top module: `rrh_buffer`

## Requirements
- R1: After reset, `busy`, `wr_en` and `clamp_err` are low and the history is empty, so a rollback request then writes nothing.
- R2: Each cycle with `issue_valid` high (and neither `busy` nor `rb_req` high) records one instruction: the (index, value) pair from each source bus. Only the newest `DEPTH` instructions are kept, and the oldest is dropped on overflow.
- R3: A request accepted at a clock edge (`rb_req` high, `busy` low) makes `busy` high from that edge for exactly 2·k cycles. In that window one write per cycle is issued, newest instruction first, and within an instruction the source-2 pair comes before the source-1 pair.
- R4: Every rollback distance from 1 to `DEPTH` is served. A rollback of `DEPTH` after at least `DEPTH` captures issues 2·`DEPTH` writes.
- R5: If `rb_count` exceeds the number of instructions held, k becomes that number and `clamp_err` is high for exactly one cycle, the first `busy` cycle.
- R6: After a restore of k instructions, those k are removed and the older ones remain for a later rollback. A register read several times in the restored span ends up holding its oldest recorded value.
- R7: `issue_valid` is ignored while `busy` is high and in the cycle in which a rollback request is accepted.
- R8: A rollback of zero, whether requested or the result of clamping, keeps `busy` high for exactly one cycle and issues no write.
- R9: `rb_req` is ignored while `busy` is high.
- R10: `wr_en` is never high while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | An instruction issued this cycle; record its operand reads |
| s1_idx | input | 5 | Register index on source-1 bus |
| s1_val | input | 32 | Value on source-1 bus |
| s2_idx | input | 5 | Register index on source-2 bus |
| s2_val | input | 32 | Value on source-2 bus |
| rb_req | input | 1 | Rollback request |
| rb_count | input | CNT_W (5) | Number of instructions to undo |
| busy | output | 1 | Restore or null rollback in progress |
| clamp_err | output | 1 | The request exceeded the history held and was clamped |
| wr_en | output | 1 | Register-file write strobe |
| wr_idx | output | 5 | Register-file write index |
| wr_data | output | 32 | Register-file write data |

## Verification
A request sampled at clock edge t shows up in the half cycle after t: `busy` and `clamp_err` rise there, and write i of the sequence appears on the write port in the half cycle after edge t+i. `busy` falls after edge t+2k, or after t+1 for a null rollback. A captured instruction first becomes visible through the next rollback. The bench advances a behavioural model at every rising edge and compares all outputs at the following falling edge, so each expected value is read exactly one register stage after its cause. Scenario checks count `busy` cycles, writes and error pulses over each request, and read back the modelled register file after the writes have landed.

// File: rtl/rrh_pkg.sv
package rrh_pkg;

    localparam int IDX_W  = 5;
    localparam int DATA_W = 32;
    localparam int LANES  = 2;

    typedef struct packed {
        logic              vld;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] val;
    } hist_entry_t;

    typedef enum logic [1:0] {
        RS_IDLE = 2'd0,
        RS_SRC2 = 2'd1,
        RS_SRC1 = 2'd2,
        RS_NULL = 2'd3
    } rs_state_e;

    function automatic hist_entry_t make_entry(logic [IDX_W-1:0] idx, logic [DATA_W-1:0] val);
        hist_entry_t e;
        e.vld = 1'b1;
        e.idx = idx;
        e.val = val;
        return e;
    endfunction

endpackage

// File: rtl/rrh_lane.sv
module rrh_lane
    import rrh_pkg::*;
#(
    parameter int DEPTH = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic              pop,
    input  logic [IDX_W-1:0]  in_idx,
    input  logic [DATA_W-1:0] in_val,
    output hist_entry_t       head
);

    hist_entry_t slot [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
        end else if (push) begin
            slot[0] <= make_entry(in_idx, in_val);
            for (int i = 1; i < DEPTH; i++) slot[i] <= slot[i-1];
        end else if (pop) begin
            for (int i = 0; i < DEPTH - 1; i++) slot[i] <= slot[i+1];
            slot[DEPTH-1] <= '0;
        end
    end

    assign head = slot[0];

endmodule

// File: rtl/rrh_ctrl.sv
module rrh_ctrl
    import rrh_pkg::*;
#(
    parameter int DEPTH = 10,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             issue_valid,
    input  logic             rb_req,
    input  logic [CNT_W-1:0] rb_count,
    output logic             push,
    output logic             pop,
    output logic             restoring,
    output logic             phase_src1,
    output logic             busy,
    output logic             clamp_err
);

    localparam int FILL_W = $clog2(DEPTH + 1);

    rs_state_e         state_q;
    logic [FILL_W-1:0] fill_q;
    logic [FILL_W-1:0] left_q;
    logic              err_q;
    logic              over;
    logic [FILL_W-1:0] req_k;

    always_comb begin
        over  = rb_count > CNT_W'(fill_q);
        req_k = over ? fill_q : FILL_W'(rb_count);
    end

    assign busy       = (state_q != RS_IDLE);
    assign restoring  = (state_q == RS_SRC2) || (state_q == RS_SRC1);
    assign phase_src1 = (state_q == RS_SRC1);
    assign pop        = (state_q == RS_SRC1);
    assign push       = (state_q == RS_IDLE) && issue_valid && !rb_req;
    assign clamp_err  = err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RS_IDLE;
            fill_q  <= '0;
            left_q  <= '0;
            err_q   <= 1'b0;
        end else begin
            err_q <= 1'b0;
            unique case (state_q)
                RS_IDLE: begin
                    if (rb_req) begin
                        err_q  <= over;
                        left_q <= req_k;
                        state_q <= (req_k == '0) ? RS_NULL : RS_SRC2;
                    end else if (push && (fill_q != FILL_W'(DEPTH))) begin
                        fill_q <= fill_q + 1'b1;
                    end
                end
                RS_SRC2: state_q <= RS_SRC1;
                RS_SRC1: begin
                    fill_q  <= fill_q - 1'b1;
                    left_q  <= left_q - 1'b1;
                    state_q <= (left_q == FILL_W'(1)) ? RS_IDLE : RS_SRC2;
                end
                RS_NULL: state_q <= RS_IDLE;
                default: state_q <= RS_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/rrh_buffer.sv
module rrh_buffer
    import rrh_pkg::*;
#(
    parameter int DEPTH = 10,
    parameter int CNT_W = $clog2(DEPTH + 1) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              issue_valid,
    input  logic [IDX_W-1:0]  s1_idx,
    input  logic [DATA_W-1:0] s1_val,
    input  logic [IDX_W-1:0]  s2_idx,
    input  logic [DATA_W-1:0] s2_val,
    input  logic              rb_req,
    input  logic [CNT_W-1:0]  rb_count,
    output logic              busy,
    output logic              clamp_err,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [DATA_W-1:0] wr_data
);

    logic push, pop, restoring, phase_src1;

    logic [IDX_W-1:0]  lane_idx [LANES];
    logic [DATA_W-1:0] lane_val [LANES];
    hist_entry_t       lane_head [LANES];
    hist_entry_t       pick;

    assign lane_idx[0] = s1_idx;
    assign lane_val[0] = s1_val;
    assign lane_idx[1] = s2_idx;
    assign lane_val[1] = s2_val;

    rrh_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .issue_valid (issue_valid),
        .rb_req      (rb_req),
        .rb_count    (rb_count),
        .push        (push),
        .pop         (pop),
        .restoring   (restoring),
        .phase_src1  (phase_src1),
        .busy        (busy),
        .clamp_err   (clamp_err)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        rrh_lane #(.DEPTH(DEPTH)) u_lane (
            .clk    (clk),
            .rst    (rst),
            .push   (push),
            .pop    (pop),
            .in_idx (lane_idx[g]),
            .in_val (lane_val[g]),
            .head   (lane_head[g])
        );
    end

    // Source 2 is restored before source 1 of the same instruction.
    assign pick    = phase_src1 ? lane_head[0] : lane_head[1];
    assign wr_en   = restoring && pick.vld;
    assign wr_idx  = pick.idx;
    assign wr_data = pick.val;

endmodule

// File: rtl/rrh_buffer_chk.sv
module rrh_buffer_chk #(
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             rb_req,
    input logic [CNT_W-1:0] rb_count,
    input logic             busy,
    input logic             clamp_err,
    input logic             wr_en
);

    AST_WRITE_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> busy); // R10

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
        (!busy && rb_req) |=> busy); // R3

    AST_ERR_FIRST_CYCLE: assert property (@(posedge clk) disable iff (rst)
        clamp_err |-> (busy && !$past(busy))); // R5

    AST_ZERO_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (!busy && rb_req && rb_count == '0) |=> (busy && !wr_en)); // R8

    AST_IDLE_BUSY_ENDS: assert property (@(posedge clk) disable iff (rst)
        (busy && !wr_en) |=> !busy); // R8

endmodule

bind rrh_buffer rrh_buffer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .rb_req    (rb_req),
    .rb_count  (rb_count),
    .busy      (busy),
    .clamp_err (clamp_err),
    .wr_en     (wr_en)
);

// File: tb/rrh_buffer_tb.sv
module rrh_buffer_tb;
    import rrh_pkg::*;

    localparam int N     = 10;
    localparam int CNT_W = $clog2(N + 1) + 1;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              issue_valid = 1'b0;
    logic [IDX_W-1:0]  s1_idx = '0, s2_idx = '0;
    logic [DATA_W-1:0] s1_val = '0, s2_val = '0;
    logic              rb_req = 1'b0;
    logic [CNT_W-1:0]  rb_count = '0;
    logic              busy, clamp_err, wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [DATA_W-1:0] wr_data;

    always #2 clk = ~clk;

    rrh_buffer #(.DEPTH(N)) u_dut (
        .clk(clk), .rst(rst), .issue_valid(issue_valid),
        .s1_idx(s1_idx), .s1_val(s1_val), .s2_idx(s2_idx), .s2_val(s2_val),
        .rb_req(rb_req), .rb_count(rb_count),
        .busy(busy), .clamp_err(clamp_err),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
    );

    typedef struct {
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] val;
    } pair_t;

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(string tag, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Register file written by the DUT
    logic [DATA_W-1:0] rf [32];
    always @(posedge clk) if (wr_en) rf[wr_idx] <= wr_data;

    // Behavioural reference
    pair_t q1[$], q2[$], wl[$];
    bit    m_busy = 0, m_err = 0;

    always @(posedge clk) begin
        if (rst) begin
            q1.delete(); q2.delete(); wl.delete();
            m_busy = 0; m_err = 0;
        end else begin
            m_err = 0;
            if (m_busy) begin
                if (wl.size() > 0) void'(wl.pop_front());
                if (wl.size() == 0) m_busy = 0;
            end else if (rb_req) begin
                int k;
                k = (int'(rb_count) > q1.size()) ? q1.size() : int'(rb_count);
                m_err = int'(rb_count) > q1.size();
                for (int i = 0; i < k; i++) begin
                    wl.push_back(q2.pop_front());
                    wl.push_back(q1.pop_front());
                end
                m_busy = 1;
            end else if (issue_valid) begin
                pair_t a, b;
                a.idx = s1_idx; a.val = s1_val;
                b.idx = s2_idx; b.val = s2_val;
                q1.push_front(a); q2.push_front(b);
                if (q1.size() > N) begin void'(q1.pop_back()); void'(q2.pop_back()); end
            end
        end
    end

    // Per-cycle comparison and scenario bookkeeping
    int    bcnt = 0, wcnt = 0, ecnt = 0;
    pair_t wlog[$];

    always @(negedge clk) begin
        if (!rst) begin
            bit exp_we;
            exp_we = m_busy && (wl.size() > 0);
            chk("R3 busy", busy, m_busy);
            chk("R5 clamp_err", clamp_err, m_err);
            chk("R3 wr_en", wr_en, exp_we);
            if (exp_we) begin
                chk("R3 wr_idx", wr_idx, wl[0].idx);
                chk("R3 wr_data", wr_data, wl[0].val);
            end
            if (busy) bcnt++;
            if (clamp_err) ecnt++;
            if (wr_en) begin
                pair_t p;
                p.idx = wr_idx; p.val = wr_data;
                wcnt++;
                wlog.push_back(p);
            end
        end
    end

    task automatic clr();
        bcnt = 0; wcnt = 0; ecnt = 0;
        wlog.delete();
    endtask

    task automatic issue(logic [4:0] i1, logic [31:0] v1, logic [4:0] i2, logic [31:0] v2);
        issue_valid = 1; s1_idx = i1; s1_val = v1; s2_idx = i2; s2_val = v2;
        @(negedge clk);
        issue_valid = 0;
    endtask

    task automatic rollback(int k);
        clr();
        rb_req = 1; rb_count = CNT_W'(k);
        @(negedge clk);
        rb_req = 0;
        while (busy) @(negedge clk);
        #1;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) rf[i] = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        chk("R1 busy after reset", busy, 0);
        chk("R1 wr_en after reset", wr_en, 0);
        chk("R1 clamp_err after reset", clamp_err, 0);
        @(negedge clk);

        // Empty history: clamped to zero
        rollback(2);
        chk("R1 empty history writes", wcnt, 0);
        chk("R5 clamp pulse count", ecnt, 1);
        chk("R8 clamped-zero busy cycles", bcnt, 1);

        // Ordering
        for (int i = 0; i < 4; i++) issue(5'(i + 1), 32'h100 + i, 5'(i + 9), 32'h200 + i);
        rollback(2);
        chk("R3 write count", wcnt, 4);
        chk("R3 busy cycles", bcnt, 4);
        chk("R3 first idx src2 newest", wlog[0].idx, 12);
        chk("R3 first data", wlog[0].val, 32'h203);
        chk("R3 second data src1 newest", wlog[1].val, 32'h103);
        chk("R3 last data", wlog[3].val, 32'h102);

        rollback(0);
        chk("R8 zero busy cycles", bcnt, 1);
        chk("R8 zero writes", wcnt, 0);
        chk("R8 zero no error", ecnt, 0);

        rollback(2);
        chk("R6 older entries kept count", wcnt, 4);
        chk("R6 older first data", wlog[0].val, 32'h201);
        chk("R6 no clamp", ecnt, 0);

        // Overflow and full distance
        for (int j = 0; j < 13; j++) issue(5'd1, 32'h1000 + j, 5'd2, 32'h2000 + j);
        rollback(N);
        chk("R4 full distance writes", wcnt, 2 * N);
        chk("R4 no clamp", ecnt, 0);
        chk("R2 newest kept", wlog[0].val, 32'h200C);
        chk("R2 oldest kept", wlog[2*N-1].val, 32'h1003);

        // Oldest value wins
        issue(5'd3, 32'd100, 5'd7, 32'd7);
        issue(5'd3, 32'd200, 5'd7, 32'd8);
        issue(5'd3, 32'd300, 5'd7, 32'd9);
        rollback(3);
        chk("R6 reg3 oldest", rf[3], 32'd100);
        chk("R6 reg7 oldest", rf[7], 32'd7);

        // Capture and requests ignored during rollback
        for (int i = 0; i < 3; i++) issue(5'd5, 32'h50 + i, 5'd6, 32'h60 + i);
        clr();
        rb_req = 1; rb_count = 1;
        issue_valid = 1; s1_idx = 5'd8; s1_val = 32'hDEAD0000; s2_idx = 5'd9; s2_val = 32'hDEAD0001;
        @(negedge clk);
        rb_count = 3;
        s1_val = 32'hDEAD0002; s2_val = 32'hDEAD0003;
        while (busy) @(negedge clk);
        rb_req = 0; issue_valid = 0;
        #1;
        chk("R9 busy not extended", bcnt, 2);
        chk("R9 writes for one instr", wcnt, 2);
        rollback(N);
        chk("R7 remaining writes", wcnt, 4);
        chk("R5 clamp on oversize", ecnt, 1);
        begin
            int dead = 0;
            foreach (wlog[i]) if (wlog[i].val[31:16] == 16'hDEAD) dead++;
            chk("R7 ignored capture absent", dead, 0);
        end

        // Mixed traffic
        for (int it = 0; it < 300; it++) begin
            if ($urandom_range(0, 9) < 7)
                issue(5'($urandom_range(0, 31)), $urandom, 5'($urandom_range(0, 31)), $urandom);
            else
                rollback($urandom_range(0, N + 3));
        end

        repeat (2) @(negedge clk);
        summary();
        $finish;
    end

endmodule